// File: doc/BRIEF.md
# Transmit FIFO Flush Controller

This block sequences flush operations for a bank of transmit FIFOs inside a serial bus controller that can act either as host or as device. Software writes a FIFO selector together with a flush request bit through a small write port. The block captures the selector and the operating mode at the moment it accepts the request. It then holds the request until the transfer engines report that no transaction is touching any transmit FIFO. Once they are quiet, it pulses a pointer-reset line for each FIFO being flushed, and afterwards clears the request bit by itself.

The selector names one FIFO by its index, or every FIFO at once through a dedicated code. In host mode only the first two FIFOs exist. Index 0 is the non-periodic queue and index 1 is the periodic queue. Every other single-FIFO code then does nothing. The block also presents two read-only status bits, both registered from inputs: a bus-master idle flag that resets to 1, and a DMA-request debug flag that resets to 0.

Top module: `txflush_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears the selector readback to 0, clears `flush_pend_o`, drives `ptr_rst_o` to all zeros, sets `bm_idle_o` to 1 and sets `dma_req_o` to 0.
- R2: Every `wr_en` cycle updates `sel_o` from `wr_sel`. When `wr_flush` is also 1 and no flush is pending, `flush_pend_o` reads 1 from the following cycle onward.
- R3: While `xfer_busy` is 1 at a clock edge, a pending flush does not proceed: `ptr_rst_o` stays zero and `flush_pend_o` stays 1.
- R4: In device mode (`host_mode`=0 when the request is accepted), selector values 0 to 6 pulse the bit of `ptr_rst_o` whose index equals the selector. The pulse lasts exactly one cycle and follows the first edge, after acceptance, at which `xfer_busy` is 0.
- R5: Selector value 16 in device mode pulses every bit of `ptr_rst_o` together for one cycle.
- R6: In host mode, selector 0 pulses bit 0 only, selector 1 pulses bit 1 only, and selector 16 pulses bits 0 and 1 only. Selectors 2 to 6 pulse nothing.
- R7: A selector outside 0 to 6 and not equal to 16 pulses nothing. The request still completes with the normal timing.
- R8: `flush_pend_o` returns to 0 one cycle after the pulse cycle, including when the pulse is empty, and `ptr_rst_o` is zero in that cycle.
- R9: While a flush is pending, further writes change `sel_o` but do not change which FIFOs the pending flush resets. A `wr_flush` write during that time starts no second flush.
- R10: `bm_idle_o` equals the inverse of `bm_busy`, and `dma_req_o` equals `dma_req_in`, each as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_mode | input | 1 | 1 = host operation, 0 = device operation |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 5 | FIFO selector written with the strobe |
| wr_flush | input | 1 | Flush request bit written with the strobe (1 requests) |
| xfer_busy | input | 1 | A transaction is reading or writing a transmit FIFO |
| bm_busy | input | 1 | Bus-master state machine is not idle |
| dma_req_in | input | 1 | DMA request in progress |
| sel_o | output | 5 | Selector readback |
| flush_pend_o | output | 1 | Flush request bit readback, self-clearing |
| bm_idle_o | output | 1 | Bus-master idle status |
| dma_req_o | output | 1 | DMA request debug status |
| ptr_rst_o | output | 7 | One-cycle pointer reset, one bit per FIFO |

## Verification
The hardest situation to reach is a second register write that lands while a flush is held back by a busy transfer engine. That write must move the selector readback but leave the latched target untouched, and its flush bit must be dropped. The bench holds `xfer_busy` high for a chosen number of cycles after acceptance and issues the interfering write inside that window. It then releases the engines and confirms that the pulse matches the original selector and that no second pulse follows. Random rounds mix modes, legal and illegal codes and busy stretches of different lengths.

// File: rtl/txflush_pkg.sv
package txflush_pkg;

   typedef enum logic [1:0] {
      FL_IDLE  = 2'd0,
      FL_WAIT  = 2'd1,
      FL_PULSE = 2'd2
   } fl_state_e;

endpackage

// File: rtl/txflush_decode.sv
module txflush_decode #(
   parameter int NUM_FIFO   = 7,
   parameter int HOST_FIFOS = 2,
   parameter int SEL_W      = 5,
   parameter int ALL_CODE   = 16
) (
   input  logic [SEL_W-1:0]    sel,
   input  logic                host,
   output logic [NUM_FIFO-1:0] mask
);

   localparam logic [SEL_W-1:0] ALL_SEL = SEL_W'(ALL_CODE);

   logic all_hit;
   assign all_hit = (sel == ALL_SEL);

   for (genvar i = 0; i < NUM_FIFO; i++) begin : g_bit
      logic one_hit;
      assign one_hit = (sel == SEL_W'(i));
      if (i < HOST_FIFOS) begin : g_shared
         assign mask[i] = one_hit | all_hit;
      end else begin : g_devonly
         assign mask[i] = ~host & (one_hit | all_hit);
      end
   end

   // R4
   always_comb begin
      if (!all_hit) begin
         single_sel_chk: assert ($countones(mask) <= 1)
            else $error("single selector decoded to several FIFOs");
      end
   end

endmodule

// File: rtl/txflush_seq.sv
module txflush_seq
   import txflush_pkg::*;
#(
   parameter int NUM_FIFO = 7,
   parameter int SEL_W    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                accept,
   input  logic [SEL_W-1:0]    acc_sel,
   input  logic                acc_host,
   input  logic                xfer_busy,
   input  logic [NUM_FIFO-1:0] tgt_mask,
   output logic [SEL_W-1:0]    lat_sel,
   output logic                lat_host,
   output logic                pending,
   output logic [NUM_FIFO-1:0] ptr_rst
);

   fl_state_e state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= FL_IDLE;
         lat_sel  <= '0;
         lat_host <= 1'b0;
         ptr_rst  <= '0;
      end else begin
         unique case (state_q)
            FL_IDLE: begin
               ptr_rst <= '0;
               if (accept) begin
                  lat_sel  <= acc_sel;
                  lat_host <= acc_host;
                  state_q  <= FL_WAIT;
               end
            end
            FL_WAIT: begin
               if (!xfer_busy) begin
                  ptr_rst <= tgt_mask;
                  state_q <= FL_PULSE;
               end
            end
            FL_PULSE: begin
               ptr_rst <= '0;
               state_q <= FL_IDLE;
            end
            default: begin
               ptr_rst <= '0;
               state_q <= FL_IDLE;
            end
         endcase
      end
   end

   assign pending = (state_q != FL_IDLE);

   // R3
   no_flush_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_rst != '0) |-> $past(!xfer_busy))
      else $error("pointer reset while engines busy");

   // R4
   single_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_rst != '0) |=> (ptr_rst == '0))
      else $error("pointer reset longer than one cycle");

   // R8
   clear_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_rst != '0) |=> !pending)
      else $error("request bit not cleared after pulse");

   // R8
   pulse_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_rst != '0) |-> pending)
      else $error("pulse without a pending request");

   // R9
   target_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && $past(pending)) |-> ($stable(lat_sel) && $stable(lat_host)))
      else $error("latched target changed during a pending flush");

endmodule

// File: rtl/txflush_stat.sv
module txflush_stat (
   input  logic clk,
   input  logic rst_n,
   input  logic bm_busy,
   input  logic dma_req_in,
   output logic bm_idle,
   output logic dma_req
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bm_idle <= 1'b1;
         dma_req <= 1'b0;
      end else begin
         bm_idle <= ~bm_busy;
         dma_req <= dma_req_in;
      end
   end

   // R10
   idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (bm_idle == !$past(bm_busy)))
      else $error("idle flag does not track bus master");

   // R1
   status_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (bm_idle && !dma_req))
      else $error("status bits wrong after reset");

endmodule

// File: rtl/txflush_ctrl.sv
module txflush_ctrl #(
   parameter int NUM_FIFO   = 7,
   parameter int HOST_FIFOS = 2,
   parameter int SEL_W      = 5,
   parameter int ALL_CODE   = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_mode,
   input  logic                wr_en,
   input  logic [SEL_W-1:0]    wr_sel,
   input  logic                wr_flush,
   input  logic                xfer_busy,
   input  logic                bm_busy,
   input  logic                dma_req_in,
   output logic [SEL_W-1:0]    sel_o,
   output logic                flush_pend_o,
   output logic                bm_idle_o,
   output logic                dma_req_o,
   output logic [NUM_FIFO-1:0] ptr_rst_o
);

   if (NUM_FIFO < 1 || NUM_FIFO > ALL_CODE) begin : g_bad_num
      $error("NUM_FIFO must lie between 1 and ALL_CODE");
   end
   if (HOST_FIFOS < 1 || HOST_FIFOS > NUM_FIFO) begin : g_bad_host
      $error("HOST_FIFOS must lie between 1 and NUM_FIFO");
   end
   if (ALL_CODE >= (1 << SEL_W)) begin : g_bad_all
      $error("ALL_CODE does not fit in SEL_W bits");
   end

   logic [SEL_W-1:0]    sel_q;
   logic [SEL_W-1:0]    lat_sel;
   logic                lat_host;
   logic                pending;
   logic                accept;
   logic [NUM_FIFO-1:0] tgt_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else if (wr_en) begin
         sel_q <= wr_sel;
      end
   end

   assign accept = wr_en & wr_flush & ~pending;

   txflush_decode #(
      .NUM_FIFO   (NUM_FIFO),
      .HOST_FIFOS (HOST_FIFOS),
      .SEL_W      (SEL_W),
      .ALL_CODE   (ALL_CODE)
   ) u_decode (
      .sel  (lat_sel),
      .host (lat_host),
      .mask (tgt_mask)
   );

   txflush_seq #(
      .NUM_FIFO (NUM_FIFO),
      .SEL_W    (SEL_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .acc_sel   (wr_sel),
      .acc_host  (host_mode),
      .xfer_busy (xfer_busy),
      .tgt_mask  (tgt_mask),
      .lat_sel   (lat_sel),
      .lat_host  (lat_host),
      .pending   (pending),
      .ptr_rst   (ptr_rst_o)
   );

   txflush_stat u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .bm_busy    (bm_busy),
      .dma_req_in (dma_req_in),
      .bm_idle    (bm_idle_o),
      .dma_req    (dma_req_o)
   );

   assign sel_o        = sel_q;
   assign flush_pend_o = pending;

   // R2
   accept_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_flush && !flush_pend_o) |=> flush_pend_o)
      else $error("accepted request not pending");

   // R6
   host_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_host && ptr_rst_o != '0) |-> ((ptr_rst_o >> HOST_FIFOS) == '0))
      else $error("host flush touched a device-only FIFO");

endmodule

// File: tb/txflush_ctrl_tb.sv
module txflush_ctrl_tb;

   localparam int N  = 7;
   localparam int SW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_mode = 1'b0;
   logic          wr_en = 1'b0;
   logic [SW-1:0] wr_sel = '0;
   logic          wr_flush = 1'b0;
   logic          xfer_busy = 1'b0;
   logic          bm_busy = 1'b0;
   logic          dma_req_in = 1'b0;
   logic [SW-1:0] sel_o;
   logic          flush_pend_o;
   logic          bm_idle_o;
   logic          dma_req_o;
   logic [N-1:0]  ptr_rst_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   txflush_ctrl u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .host_mode    (host_mode),
      .wr_en        (wr_en),
      .wr_sel       (wr_sel),
      .wr_flush     (wr_flush),
      .xfer_busy    (xfer_busy),
      .bm_busy      (bm_busy),
      .dma_req_in   (dma_req_in),
      .sel_o        (sel_o),
      .flush_pend_o (flush_pend_o),
      .bm_idle_o    (bm_idle_o),
      .dma_req_o    (dma_req_o),
      .ptr_rst_o    (ptr_rst_o)
   );

   function automatic logic [N-1:0] exp_mask(input logic host, input logic [SW-1:0] s);
      if (s == 5'd16) return host ? 7'b0000011 : 7'b1111111;
      if (s <= 5'd1) return 7'(1) << s;
      if (s <= 5'd6) return host ? 7'b0 : (7'(1) << s);
      return 7'b0;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // one flush: request on this negedge, engines busy for busy_n cycles
   task automatic do_flush(input logic host, input logic [SW-1:0] s, input int busy_n,
                           input bit interfere, input string req);
      logic [N-1:0] m;
      m = exp_mask(host, s);
      @(negedge clk);
      host_mode = host; wr_en = 1'b1; wr_sel = s; wr_flush = 1'b1;
      xfer_busy = (busy_n > 0);
      @(negedge clk);
      wr_en = 1'b0; wr_flush = 1'b0; host_mode = $urandom_range(0, 1);
      chk("R2 pend", flush_pend_o, 1);
      chk("R2 sel", sel_o, s);
      for (int i = 0; i < busy_n; i++) begin
         if (interfere && i == 0) begin
            wr_en = 1'b1; wr_sel = s ^ 5'd3; wr_flush = 1'b1;
         end
         @(negedge clk);
         wr_en = 1'b0; wr_flush = 1'b0;
         chk("R3 hold ptr", ptr_rst_o, 0);
         chk("R3 hold pend", flush_pend_o, 1);
         if (interfere && i == 0) chk("R9 sel readback", sel_o, s ^ 5'd3);
      end
      xfer_busy = 1'b0;
      @(negedge clk);
      chk(req, ptr_rst_o, m);
      chk("R8 pend in pulse", flush_pend_o, 1);
      @(negedge clk);
      chk("R8 pend cleared", flush_pend_o, 0);
      chk("R8 ptr low", ptr_rst_o, 0);
      if (interfere) begin
         for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9 no second flush", {flush_pend_o, ptr_rst_o}, 0);
         end
      end
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      chk("R1 sel", sel_o, 0);
      chk("R1 pend", flush_pend_o, 0);
      chk("R1 ptr", ptr_rst_o, 0);
      chk("R1 idle", bm_idle_o, 1);
      chk("R1 dma", dma_req_o, 0);
      rst_n = 1'b1;

      // directed corners
      for (int k = 0; k < 7; k++) do_flush(1'b0, SW'(k), k % 3, 1'b0, "R4 device single");
      do_flush(1'b0, 5'd16, 2, 1'b0, "R5 device all");
      do_flush(1'b1, 5'd0, 0, 1'b0, "R6 host nonperiodic");
      do_flush(1'b1, 5'd1, 1, 1'b0, "R6 host periodic");
      do_flush(1'b1, 5'd16, 0, 1'b0, "R6 host all");
      do_flush(1'b1, 5'd4, 1, 1'b0, "R6 host noop");
      do_flush(1'b0, 5'd9, 0, 1'b0, "R7 unsupported");
      do_flush(1'b0, 5'd31, 2, 1'b0, "R7 unsupported");
      do_flush(1'b0, 5'd2, 3, 1'b1, "R9 latched target");
      do_flush(1'b1, 5'd16, 2, 1'b1, "R9 latched target");

      // random rounds
      for (int r = 0; r < 60; r++) begin
         logic [SW-1:0] s;
         int pick;
         pick = $urandom_range(0, 9);
         s = (pick < 7) ? SW'(pick) : (pick == 7 ? 5'd16 : SW'($urandom_range(0, 31)));
         do_flush(1'($urandom_range(0, 1)), s, $urandom_range(0, 3),
                  1'($urandom_range(0, 4) == 0), "R4 R5 R6 R7 random");
      end

      // status bits
      for (int c = 0; c < 40; c++) begin
         logic b, d;
         b = 1'($urandom_range(0, 1));
         d = 1'($urandom_range(0, 1));
         bm_busy = b; dma_req_in = d;
         @(negedge clk);
         chk("R10 idle", bm_idle_o, !b);
         chk("R10 dma", dma_req_o, d);
      end

      // reset mid-flight
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 5'd5; wr_flush = 1'b1; xfer_busy = 1'b1; bm_busy = 1'b1; dma_req_in = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_flush = 1'b0; rst_n = 1'b0;
      @(negedge clk);
      chk("R1 pend after reset", flush_pend_o, 0);
      chk("R1 sel after reset", sel_o, 0);
      chk("R1 idle after reset", bm_idle_o, 1);
      chk("R1 dma after reset", dma_req_o, 0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule